// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides, every cycle, which of a bank of interrupt request lines should be presented to a processor. It receives the pending-request vector and the mask vector from surrounding logic, keeps the in-service vector and a rotation base of its own, and drives an interrupt output together with the index of the winning line. The scheme is rotating: the line at the rotation base has the highest priority and the ranks wrap around from there. A pending line wins only if no line of equal or higher rank is already in service. Two mode inputs change what counts as "in service" for that comparison. Special mask mode drops masked lines from the in-service set. Nested mode drops the cascade input on a primary instance.

Acknowledge and end-of-interrupt traffic arrive as a one-cycle acknowledge strobe and a one-cycle command code. Both are decoded elsewhere. An acknowledge either marks the winning line as in service or, in automatic end-of-interrupt mode, leaves the in-service vector alone and may rotate the base. The commands clear in-service bits, move the rotation base, or do both. The outputs are combinational from the stored state and the inputs. Every state change takes effect at the clock edge where its strobe is high.

Top module: `rot_prio_resolver`

## Requirements
- R1: After reset the in-service vector is 0, the rotation base is 0, irq_o is 0 and line_o is 7.
- R2: Line (p + base) mod 8 has rank p, and rank 0 is the highest. The candidate is the highest-ranked bit of pend_i AND NOT mask_i. When irq_o is 1, line_o is that candidate's line number.
- R3: irq_o is 1 only when a candidate exists and its rank is strictly higher than the rank of the highest-ranked bit in the effective in-service set. If that line itself is in service, irq_o is 0.
- R4: When spec_mask_i is 1, in-service bits whose mask_i bit is 1 are removed from the effective in-service set.
- R5: When nested_i is 1 and the instance is a primary controller (parameter PRIMARY = 1), in-service bit 2 is removed from the effective in-service set.
- R6: ack_i with irq_o = 1, auto_eoi_i = 0 and cmd_i = 0 sets bit line_o of the in-service vector at that edge. ack_i while irq_o = 0 changes nothing.
- R7: ack_i with irq_o = 1 and auto_eoi_i = 1 leaves the in-service vector unchanged. If rot_aeoi_i is also 1, the base becomes (line_o + 1) mod 8.
- R8: cmd_i = 1 (non-specific end-of-interrupt) clears the highest-ranked bit of the raw in-service vector. cmd_i = 2 does the same and also sets the base to (that line + 1) mod 8.
- R9: cmd_i = 3 (specific end-of-interrupt) clears in-service bit cmd_line_i. cmd_i = 4 does the same and also sets the base to (cmd_line_i + 1) mod 8.
- R10: cmd_i = 5 (set priority) sets the base to (cmd_line_i + 1) mod 8 and leaves the in-service vector unchanged.
- R11: A non-specific end-of-interrupt (cmd_i = 1 or 2) with an empty in-service vector changes neither the in-service vector nor the base.
- R12: When cmd_i is non-zero in the same cycle as ack_i, only the command takes effect and the acknowledge is dropped. Codes 6 and 7 do nothing.
- R13: When irq_o is 0, line_o reads 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | 8 | Pending request vector |
| mask_i | input | 8 | Mask vector, 1 = line masked |
| spec_mask_i | input | 1 | Special mask mode enable |
| nested_i | input | 1 | Nested mode enable (ignores cascade line when PRIMARY) |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_aeoi_i | input | 1 | Rotate base on automatic end-of-interrupt |
| ack_i | input | 1 | Acknowledge strobe for the current winning line |
| cmd_i | input | 3 | Command code: 0 none, 1 EOI, 2 rotating EOI, 3 specific EOI, 4 rotating specific EOI, 5 set priority |
| cmd_line_i | input | 3 | Line operand for commands 3, 4 and 5 |
| irq_o | output | 1 | Interrupt request to processor |
| line_o | output | 3 | Winning line, 7 when irq_o is 0 |
| isr_o | output | 8 | In-service vector |
| base_o | output | 3 | Rotation base (line holding rank 0) |

## Verification
The assertions check the relations that hold every cycle. A raised interrupt always names a line that is pending, unmasked and not itself in service. With no interrupt, line_o reads 7. Each acknowledge, end-of-interrupt and set-priority command leaves the exact change in the in-service vector or base one edge later, and an end-of-interrupt on an empty vector leaves everything unchanged. Some behaviour only the directed scenarios can show: that the rank order truly follows the rotated base across several base values, that special mask and nested modes open a path that is otherwise blocked, and that an acknowledge is dropped when it collides with a command.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

  // Command codes delivered by the external decoder, one cycle wide.
  typedef enum logic [2:0] {
    CMD_NONE       = 3'd0,
    CMD_EOI        = 3'd1,
    CMD_EOI_ROT    = 3'd2,
    CMD_SEOI       = 3'd3,
    CMD_SEOI_ROT   = 3'd4,
    CMD_SET_PRIO   = 3'd5
  } rpr_cmd_e;

  localparam int unsigned RPR_CMD_W = 3;

endpackage

// File: rtl/rpr_prio_scan.sv
// Finds the highest-ranked set bit of a vector under a rotating base.
// N must be a power of two, so index arithmetic wraps by truncation.
module rpr_prio_scan #(
  parameter int N  = 8,
  parameter int IW = $clog2(N),
  parameter int PW = IW + 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] base,
  output logic [PW-1:0] rank,
  output logic [IW-1:0] line,
  output logic          found
);

  // Line that holds rank r under the current base.
  function automatic logic [IW-1:0] line_of_rank(input logic [IW-1:0] b,
                                                 input int unsigned r);
    logic [IW-1:0] rr;
    rr = IW'(r);
    return b + rr;
  endfunction

  always_comb begin
    rank  = PW'(N);
    line  = '0;
    found = 1'b0;
    // Scan from lowest rank to highest so that the best one lands last.
    for (int r = N - 1; r >= 0; r--) begin
      if (req[line_of_rank(base, r)]) begin
        rank  = PW'(r);
        line  = line_of_rank(base, r);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rpr_arbiter.sv
// Combinational decision: candidate versus effective in-service set.
module rpr_arbiter #(
  parameter int N       = 8,
  parameter bit PRIMARY = 1'b1,
  parameter int CASC    = 2,
  parameter int IW      = $clog2(N),
  parameter int PW      = IW + 1
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  isr,
  input  logic [IW-1:0] base,
  input  logic          spec_mask,
  input  logic          nested,
  output logic          irq,
  output logic [IW-1:0] line,
  output logic [N-1:0]  isr_eff,
  output logic          top_srv_found,
  output logic [IW-1:0] top_srv_line
);

  localparam logic [N-1:0] CASC_BIT = N'(1) << CASC;

  logic [N-1:0]  cand_vec;
  logic [PW-1:0] cand_rank;
  logic [IW-1:0] cand_line;
  logic          cand_found;
  logic [PW-1:0] blk_rank;
  logic [IW-1:0] blk_line;
  logic          blk_found;
  logic [PW-1:0] raw_rank;

  // Effective in-service set used only for the comparison.
  function automatic logic [N-1:0] filter_isr(input logic [N-1:0] s,
                                              input logic [N-1:0] m,
                                              input logic sm,
                                              input logic nest);
    logic [N-1:0] v;
    v = s;
    if (sm) v = v & ~m;
    if (nest && PRIMARY) v = v & ~CASC_BIT;
    return v;
  endfunction

  assign cand_vec = pend & ~mask;
  assign isr_eff  = filter_isr(isr, mask, spec_mask, nested);

  rpr_prio_scan #(.N(N)) u_cand (
    .req   (cand_vec),
    .base  (base),
    .rank  (cand_rank),
    .line  (cand_line),
    .found (cand_found)
  );

  rpr_prio_scan #(.N(N)) u_block (
    .req   (isr_eff),
    .base  (base),
    .rank  (blk_rank),
    .line  (blk_line),
    .found (blk_found)
  );

  // Raw in-service scan for the non-specific end-of-interrupt.
  rpr_prio_scan #(.N(N)) u_raw (
    .req   (isr),
    .base  (base),
    .rank  (raw_rank),
    .line  (top_srv_line),
    .found (top_srv_found)
  );

  logic outranks;
  assign outranks = cand_found && (cand_rank < blk_rank);

  always_comb begin
    irq  = outranks;
    line = outranks ? cand_line : IW'(N - 1);
  end

  logic unused_ok;
  assign unused_ok = ^{blk_line, blk_found, raw_rank};

endmodule

// File: rtl/rpr_state.sv
// In-service vector and rotation base, updated by acknowledge and commands.
module rpr_state
  import rpr_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack,
  input  logic          irq,
  input  logic [IW-1:0] line,
  input  logic          auto_eoi,
  input  logic          rot_aeoi,
  input  rpr_cmd_e      cmd,
  input  logic [IW-1:0] cmd_line,
  input  logic          top_srv_found,
  input  logic [IW-1:0] top_srv_line,
  output logic [N-1:0]  isr,
  output logic [IW-1:0] base,
  output logic          ack_take,
  output logic          eoi_hit
);

  function automatic logic [IW-1:0] after(input logic [IW-1:0] l);
    return l + IW'(1);
  endfunction

  logic [N-1:0]  isr_n;
  logic [IW-1:0] base_n;

  assign ack_take = ack && irq && (cmd == CMD_NONE);
  assign eoi_hit  = ((cmd == CMD_EOI) || (cmd == CMD_EOI_ROT)) && top_srv_found;

  always_comb begin
    isr_n  = isr;
    base_n = base;
    case (cmd)
      CMD_NONE: begin
        if (ack_take) begin
          if (auto_eoi) begin
            if (rot_aeoi) base_n = after(line);
          end else begin
            isr_n[line] = 1'b1;
          end
        end
      end
      CMD_EOI, CMD_EOI_ROT: begin
        if (top_srv_found) begin
          isr_n[top_srv_line] = 1'b0;
          if (cmd == CMD_EOI_ROT) base_n = after(top_srv_line);
        end
      end
      CMD_SEOI, CMD_SEOI_ROT: begin
        isr_n[cmd_line] = 1'b0;
        if (cmd == CMD_SEOI_ROT) base_n = after(cmd_line);
      end
      CMD_SET_PRIO: base_n = after(cmd_line);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr  <= '0;
      base <= '0;
    end else begin
      isr  <= isr_n;
      base <= base_n;
    end
  end

endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
  import rpr_pkg::*;
#(
  parameter int N       = 8,
  parameter bit PRIMARY = 1'b1,
  parameter int CASC    = 2,
  parameter int IW      = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         pend_i,
  input  logic [N-1:0]         mask_i,
  input  logic                 spec_mask_i,
  input  logic                 nested_i,
  input  logic                 auto_eoi_i,
  input  logic                 rot_aeoi_i,
  input  logic                 ack_i,
  input  logic [RPR_CMD_W-1:0] cmd_i,
  input  logic [IW-1:0]        cmd_line_i,
  output logic                 irq_o,
  output logic [IW-1:0]        line_o,
  output logic [N-1:0]         isr_o,
  output logic [IW-1:0]        base_o
);

  logic [N-1:0]  isr_q;
  logic [IW-1:0] base_q;
  logic [N-1:0]  isr_eff;
  logic          top_srv_found;
  logic [IW-1:0] top_srv_line;
  logic          ack_take;
  logic          eoi_hit;
  logic          irq_w;
  logic [IW-1:0] line_w;
  rpr_cmd_e      cmd_e;

  assign cmd_e = rpr_cmd_e'(cmd_i);

  rpr_arbiter #(.N(N), .PRIMARY(PRIMARY), .CASC(CASC)) u_arb (
    .pend          (pend_i),
    .mask          (mask_i),
    .isr           (isr_q),
    .base          (base_q),
    .spec_mask     (spec_mask_i),
    .nested        (nested_i),
    .irq           (irq_w),
    .line          (line_w),
    .isr_eff       (isr_eff),
    .top_srv_found (top_srv_found),
    .top_srv_line  (top_srv_line)
  );

  rpr_state #(.N(N)) u_state (
    .clk           (clk),
    .rst_n         (rst_n),
    .ack           (ack_i),
    .irq           (irq_w),
    .line          (line_w),
    .auto_eoi      (auto_eoi_i),
    .rot_aeoi      (rot_aeoi_i),
    .cmd           (cmd_e),
    .cmd_line      (cmd_line_i),
    .top_srv_found (top_srv_found),
    .top_srv_line  (top_srv_line),
    .isr           (isr_q),
    .base          (base_q),
    .ack_take      (ack_take),
    .eoi_hit       (eoi_hit)
  );

  assign irq_o  = irq_w;
  assign line_o = line_w;
  assign isr_o  = isr_q;
  assign base_o = base_q;

  logic unused_ok;
  assign unused_ok = ^{isr_eff, ack_take, eoi_hit};

endmodule

// File: rtl/rpr_checker.sv
module rpr_checker #(
  parameter int N       = 8,
  parameter bit PRIMARY = 1'b1,
  parameter int CASC    = 2,
  parameter int IW      = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  pend_i,
  input logic [N-1:0]  mask_i,
  input logic          nested_i,
  input logic          auto_eoi_i,
  input logic          ack_i,
  input logic [2:0]    cmd_i,
  input logic [IW-1:0] cmd_line_i,
  input logic          irq_o,
  input logic [IW-1:0] line_o,
  input logic [N-1:0]  isr_o,
  input logic [IW-1:0] base_o,
  input logic          ack_take,
  input logic          eoi_hit
);

  a_r2_winner_is_request: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_i[line_o] && !mask_i[line_o]));

  a_r3_not_already_served: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(nested_i && PRIMARY && line_o == IW'(CASC))) |-> !isr_o[line_o]);

  a_r13_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (line_o == IW'(N - 1)));

  a_r6_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !auto_eoi_i && cmd_i == 3'd0) |=> isr_o[$past(line_o)]);

  a_r7_auto_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && auto_eoi_i && cmd_i == 3'd0) |=> $stable(isr_o));

  a_r8_eoi_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit |=> ($countones(isr_o) + 1 == $countones($past(isr_o))));

  a_r9_seoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd3 || cmd_i == 3'd4) |=> !isr_o[$past(cmd_line_i)]);

  a_r10_set_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd5) |=> (base_o == $past(cmd_line_i) + IW'(1)));

  a_r11_empty_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_i == 3'd1 || cmd_i == 3'd2) && isr_o == '0) |=> (isr_o == '0 && $stable(base_o)));

  a_r12_cmd_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && cmd_i != 3'd0) |-> !ack_take);

endmodule

bind rot_prio_resolver rpr_checker #(.N(N), .PRIMARY(PRIMARY), .CASC(CASC)) u_rpr_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pend_i     (pend_i),
  .mask_i     (mask_i),
  .nested_i   (nested_i),
  .auto_eoi_i (auto_eoi_i),
  .ack_i      (ack_i),
  .cmd_i      (cmd_i),
  .cmd_line_i (cmd_line_i),
  .irq_o      (irq_o),
  .line_o     (line_o),
  .isr_o      (isr_o),
  .base_o     (base_o),
  .ack_take   (ack_take),
  .eoi_hit    (eoi_hit)
);

// File: tb/rot_prio_resolver_bench.sv
`timescale 1ns/1ps
module rot_prio_resolver_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pend_i = '0;
  logic [7:0] mask_i = '0;
  logic       spec_mask_i = 1'b0;
  logic       nested_i = 1'b0;
  logic       auto_eoi_i = 1'b0;
  logic       rot_aeoi_i = 1'b0;
  logic       ack_i = 1'b0;
  logic [2:0] cmd_i = '0;
  logic [2:0] cmd_line_i = '0;
  logic       irq_o;
  logic [2:0] line_o;
  logic [7:0] isr_o;
  logic [2:0] base_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rot_prio_resolver u_rot_prio_resolver (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .mask_i(mask_i),
    .spec_mask_i(spec_mask_i), .nested_i(nested_i), .auto_eoi_i(auto_eoi_i),
    .rot_aeoi_i(rot_aeoi_i), .ack_i(ack_i), .cmd_i(cmd_i), .cmd_line_i(cmd_line_i),
    .irq_o(irq_o), .line_o(line_o), .isr_o(isr_o), .base_o(base_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected {irq, line}: walk ranks, stop at first request or blocking service.
  function automatic int model(input logic [7:0] pend, input logic [7:0] msk,
                               input logic [7:0] srv, input int base,
                               input bit sm, input bit nest);
    for (int r = 0; r < 8; r++) begin
      int l;
      bit blocked;
      l = (r + base) % 8;
      blocked = srv[l] && !(sm && msk[l]) && !(nest && l == 2);
      if (blocked) return 7;
      if (pend[l] && !msk[l]) return 8 + l;
    end
    return 7;
  endfunction

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic check_out(input string req);
    int e;
    e = model(pend_i, mask_i, isr_o, int'(base_o), spec_mask_i, nested_i);
    check({req, " irq"}, int'(irq_o), (e >= 8) ? 1 : 0);
    check({req, " line"}, int'(line_o), e % 8);
  endtask

  task automatic pulse(input bit ack, input logic [2:0] cmd, input logic [2:0] ln);
    @(negedge clk);
    ack_i = ack; cmd_i = cmd; cmd_line_i = ln;
    @(negedge clk);
    ack_i = 1'b0; cmd_i = 3'd0; cmd_line_i = 3'd0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    pend_i = '0; mask_i = '0; spec_mask_i = 0; nested_i = 0; auto_eoi_i = 0; rot_aeoi_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; #1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 isr", isr_o, 0); check("R1 base", base_o, 0);
    check("R1 irq", irq_o, 0); check("R1 line", line_o, 7);
  endtask

  task automatic t_basic();
    pend_i = 8'h28; settle();
    check("R2 line", line_o, 3); check("R2 irq", irq_o, 1);
    mask_i = 8'h08; settle();
    check("R2 masked line", line_o, 5);
    mask_i = 8'h00; settle();
  endtask

  task automatic t_ack_block();
    pend_i = 8'h08; settle();
    pulse(1, 3'd0, 0);
    check("R6 isr", isr_o, 8'h08);
    pend_i = 8'h28; settle();
    check("R3 same line blocked", irq_o, 0); check("R13 line", line_o, 7);
    pend_i = 8'h02; settle();
    check("R3 higher passes", irq_o, 1); check("R3 line", line_o, 1);
    pend_i = 8'h20; settle();
    check("R3 lower blocked", irq_o, 0);
  endtask

  task automatic t_nonspec_eoi();
    pulse(0, 3'd1, 0);
    check("R8 clear", isr_o, 0); check("R8 base", base_o, 0);
    pend_i = 8'h08; settle(); pulse(1, 3'd0, 0);
    pend_i = 8'h02; settle(); pulse(1, 3'd0, 0);
    check("R6 two in service", isr_o, 8'h0A);
    pulse(0, 3'd1, 0);
    check("R8 top cleared", isr_o, 8'h08);
    pulse(0, 3'd2, 0);
    check("R8 rot clear", isr_o, 0); check("R8 rot base", base_o, 4);
    pulse(0, 3'd1, 0);
    check("R11 isr", isr_o, 0); check("R11 base", base_o, 4);
    pulse(0, 3'd2, 0);
    check("R11 rot base", base_o, 4);
  endtask

  task automatic t_rotation();
    pend_i = 8'h21; settle();
    check("R2 base4 line", line_o, 5); check_out("R2 base4");
    pulse(0, 3'd5, 3'd5);
    check("R10 base", base_o, 6); check("R10 isr", isr_o, 0);
    check("R2 base6 line", line_o, 0);
    pend_i = 8'hA0; settle();
    check("R2 base6 wrap", line_o, 7); check_out("R2 base6");
  endtask

  task automatic t_specific();
    pend_i = 8'h01; settle(); pulse(1, 3'd0, 0);
    check("R6 isr0", isr_o, 8'h01);
    pulse(0, 3'd3, 3'd0);
    check("R9 clear", isr_o, 0); check("R9 base kept", base_o, 6);
    pulse(1, 3'd0, 0);
    pulse(0, 3'd4, 3'd0);
    check("R9 rot clear", isr_o, 0); check("R9 rot base", base_o, 1);
  endtask

  task automatic t_auto();
    auto_eoi_i = 1; pend_i = 8'h10; settle();
    pulse(1, 3'd0, 0);
    check("R7 isr", isr_o, 0); check("R7 base kept", base_o, 1);
    rot_aeoi_i = 1;
    pulse(1, 3'd0, 0);
    check("R7 rot base", base_o, 5); check("R7 isr rot", isr_o, 0);
    auto_eoi_i = 0; rot_aeoi_i = 0;
  endtask

  task automatic t_spec_mask();
    do_reset();
    pend_i = 8'h02; settle(); pulse(1, 3'd0, 0);
    pend_i = 8'h20; settle();
    check("R4 blocked", irq_o, 0);
    mask_i = 8'h02; spec_mask_i = 1; settle();
    check("R4 opened", irq_o, 1); check("R4 line", line_o, 5);
    spec_mask_i = 0; settle();
    check("R4 off blocked", irq_o, 0);
    mask_i = 0;
  endtask

  task automatic t_nested();
    do_reset();
    pend_i = 8'h04; settle(); pulse(1, 3'd0, 0);
    check("R5 isr", isr_o, 8'h04);
    check("R5 off blocked", irq_o, 0);
    nested_i = 1; settle();
    check("R5 cascade again", irq_o, 1); check("R5 line", line_o, 2);
    pend_i = 8'h08; settle();
    check("R5 lower passes", irq_o, 1); check_out("R5");
    nested_i = 0; settle();
    check("R5 off lower blocked", irq_o, 0);
  endtask

  task automatic t_collide();
    pend_i = 8'h02; settle();
    check("R12 irq before", irq_o, 1);
    pulse(1, 3'd3, 3'd2);
    check("R12 ack dropped", isr_o, 0);
    pulse(1, 3'd6, 3'd0);
    check("R12 code6 noop isr", isr_o, 0); check("R12 code6 noop base", base_o, 0);
    pulse(1, 3'd0, 0);
    check("R6 isr1", isr_o, 8'h02);
    pend_i = 8'h00; settle();
    check("R13 idle", line_o, 7);
    pulse(1, 3'd0, 0);
    check("R6 ack idle ignored", isr_o, 8'h02);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_ack_block();
    t_nonspec_eoi();
    t_rotation();
    t_specific();
    t_auto();
    t_spec_mask();
    t_nested();
    t_collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule